// File: doc/BRIEF.md
# PCIe Link Recovery Sequencer

This block restores a PCIe root-port link after it has gone down, with no software involved. A single start pulse runs a fixed series of register writes toward the controller and PHY configuration space. The series first turns the link training state machine off. It then rewrites every PHY setting that was overridden earlier, because those settings fall back to their reset values when the link drops. Next it caps the link at the first-generation rate and turns training back on. The block then watches the reported training state until the link is confirmed in L0.

After that first L0, the block raises the speed cap to the second-generation rate and asks the controller for a directed speed change. It then waits for L0 a second time. Each wait has a cycle limit taken from an input. If a wait runs past its limit, the sequence stops in an error condition, and that condition stays visible until the next start. Writes leave through a simple valid/ready master port with one write per accepted handshake.

The PHY override table is set by parameters and holds 1 to 8 address/data pairs. The register addresses and base contents are also parameters.

Top module: `lr_link_recovery_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, `busy_o`, `done_o`, `error_o` and `wr_valid_o` are all 0.
- R2: A start pulse from idle or error makes the first write go to `CTRL_ADDR`. Its data is `CTRL_BASE` with bit 10, the training enable bit, cleared.
- R3: Next come writes of the `OVR_COUNT` override entries, from entry 0 to entry `OVR_COUNT-1`. Each write uses that entry's address and data.
- R4: Next comes a write to `LCAP_ADDR` carrying `LCAP_BASE` with bits [3:0] set to 4'b0001. It is followed by a write to `CTRL_ADDR` carrying `CTRL_BASE` with bit 10 set. After that no write is issued until L0 is confirmed.
- R5: L0 is confirmed only when `ltssm_state_i` equals 17 on two consecutive cycles of a wait phase. A single-cycle 17 does not count.
- R6: After the first L0 the block writes `LCAP_ADDR` with bits [3:0] set to 4'b0010. It then writes `G2_ADDR` with `G2_BASE` with bit 17 set, and waits for L0 again.
- R7: In each wait phase, the cycles are counted from 0 starting at the first cycle of the phase. If L0 is not confirmed by the cycle whose count equals `timeout_i`, the block drops `busy_o` and raises `error_o` on the next cycle. `error_o` stays high until a new start.
- R8: `busy_o` is high from the cycle after an accepted start until the sequence ends. A start that arrives while busy has no effect on the writes or the status.
- R9: When the second L0 is confirmed, `done_o` is high for exactly one cycle, and `busy_o` falls in that same cycle.
- R10: While `wr_valid_o` is high and `wr_ready_i` is low, the address and data hold steady. Each cycle with both high completes exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the recovery sequence |
| ltssm_state_i | input | LW | Current link training state code |
| timeout_i | input | TW | Cycle limit for each L0 wait |
| wr_valid_o | output | 1 | Register write request valid |
| wr_ready_i | input | 1 | Register write accepted |
| wr_addr_o | output | AW | Register write address |
| wr_data_o | output | DW | Register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the link is back at the higher rate |
| error_o | output | 1 | A wait phase timed out; held until the next start |

## Verification
A wrong step in the write sequence shows up on the write port in the very cycle the write is offered. The bench compares each offered address and data against the order the requirements give. A faulty L0 filter or a faulty timeout counter changes when the next write appears or when error rises, so the per-cycle reference comparison catches it one cycle after the bad decision. Three things are held to the exact cycle: that a start during a sequence is ignored, that done is a single-cycle pulse, and that error holds once raised.

// File: rtl/lr_pkg.sv
package lr_pkg;

  localparam int OVR_SLOTS = 8;
  localparam int OVR_IW    = $clog2(OVR_SLOTS);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIS,
    ST_OVR,
    ST_CAP1,
    ST_EN,
    ST_WAIT1,
    ST_CAP2,
    ST_SPD,
    ST_WAIT2,
    ST_ERR
  } seq_state_t;

endpackage

// File: rtl/lr_ovr_table.sv
module lr_ovr_table #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [lr_pkg::OVR_SLOTS*AW-1:0] ADDRS = '0,
  parameter logic [lr_pkg::OVR_SLOTS*DW-1:0] DATAS = '0
) (
  input  logic [lr_pkg::OVR_IW-1:0] idx,
  output logic [AW-1:0]             addr,
  output logic [DW-1:0]             data
);
  logic [AW-1:0] addr_tab [lr_pkg::OVR_SLOTS];
  logic [DW-1:0] data_tab [lr_pkg::OVR_SLOTS];

  for (genvar g = 0; g < lr_pkg::OVR_SLOTS; g++) begin : g_slot
    assign addr_tab[g] = ADDRS[g*AW +: AW];
    assign data_tab[g] = DATAS[g*DW +: DW];
  end

  assign addr = addr_tab[idx];
  assign data = data_tab[idx];
endmodule

// File: rtl/lr_l0_detect.sv
module lr_l0_detect #(
  parameter int LW      = 6,
  parameter int TW      = 16,
  parameter int L0_CODE = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [LW-1:0] ltssm,
  input  logic [TW-1:0] limit,
  output logic          hit,
  output logic          tmo
);
  localparam logic [LW-1:0] L0_VAL = LW'(L0_CODE);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic          match;
  logic          seen_q;
  logic [TW-1:0] cnt_q;

  assign match = (ltssm == L0_VAL);
  assign hit   = arm && seen_q && match;
  assign tmo   = arm && !hit && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= match;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lr_wr_port.sv
module lr_wr_port #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data,
  output logic          accept
);
  assign accept = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (accept) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lr_link_recovery_seq.sv
module lr_link_recovery_seq
  import lr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int LW        = 6,
  parameter int TW        = 16,
  parameter int L0_CODE   = 17,
  parameter int EN_BIT    = 10,
  parameter int SPD_BIT   = 17,
  parameter int OVR_COUNT = 3,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h0030,
  parameter logic [AW-1:0] LCAP_ADDR = 16'h007C,
  parameter logic [AW-1:0] G2_ADDR   = 16'h080C,
  parameter logic [DW-1:0] CTRL_BASE = 32'h0820_0400,
  parameter logic [DW-1:0] LCAP_BASE = 32'h0003_F412,
  parameter logic [DW-1:0] G2_BASE   = 32'h0000_010F,
  parameter logic [OVR_SLOTS*AW-1:0] OVR_ADDRS = '0,
  parameter logic [OVR_SLOTS*DW-1:0] OVR_DATAS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [LW-1:0] ltssm_state_i,
  input  logic [TW-1:0] timeout_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);
  localparam logic [DW-1:0] EN_MASK  = DW'(1) << EN_BIT;
  localparam logic [DW-1:0] SPD_MASK = DW'(1) << SPD_BIT;
  localparam logic [DW-1:0] D_DIS  = CTRL_BASE & ~EN_MASK;
  localparam logic [DW-1:0] D_EN   = CTRL_BASE | EN_MASK;
  localparam logic [DW-1:0] D_CAP1 = {LCAP_BASE[DW-1:4], 4'b0001};
  localparam logic [DW-1:0] D_CAP2 = {LCAP_BASE[DW-1:4], 4'b0010};
  localparam logic [DW-1:0] D_SPD  = G2_BASE | SPD_MASK;
  localparam logic [OVR_IW-1:0] OVR_LAST = OVR_IW'(OVR_COUNT - 1);

  seq_state_t        state_q, state_n;
  logic [OVR_IW-1:0] idx_q, idx_n;
  logic              busy_n, err_n, done_n;
  logic              load;
  logic [AW-1:0]     ld_addr;
  logic [DW-1:0]     ld_data;
  logic              accept;
  logic              arm, hit, tmo;
  logic [AW-1:0]     tab_addr;
  logic [DW-1:0]     tab_data;

  lr_ovr_table #(
    .AW(AW), .DW(DW), .ADDRS(OVR_ADDRS), .DATAS(OVR_DATAS)
  ) u_tab (
    .idx(idx_n), .addr(tab_addr), .data(tab_data)
  );

  assign arm = (state_q == ST_WAIT1) || (state_q == ST_WAIT2);

  lr_l0_detect #(
    .LW(LW), .TW(TW), .L0_CODE(L0_CODE)
  ) u_det (
    .clk(clk), .rst(rst), .arm(arm), .ltssm(ltssm_state_i),
    .limit(timeout_i), .hit(hit), .tmo(tmo)
  );

  lr_wr_port #(
    .AW(AW), .DW(DW)
  ) u_wr (
    .clk(clk), .rst(rst), .load(load), .ld_addr(ld_addr), .ld_data(ld_data),
    .ready(wr_ready_i), .valid(wr_valid_o), .addr(wr_addr_o),
    .data(wr_data_o), .accept(accept)
  );

  // Next-state and write-issue decision
  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    load    = 1'b0;
    busy_n  = busy_o;
    err_n   = error_o;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_ERR: begin
        if (start_i) begin
          state_n = ST_DIS;
          load    = 1'b1;
          busy_n  = 1'b1;
          err_n   = 1'b0;
        end
      end
      ST_DIS: begin
        if (accept) begin
          state_n = ST_OVR;
          idx_n   = '0;
          load    = 1'b1;
        end
      end
      ST_OVR: begin
        if (accept) begin
          load = 1'b1;
          if (idx_q == OVR_LAST) state_n = ST_CAP1;
          else                   idx_n   = idx_q + 1'b1;
        end
      end
      ST_CAP1: begin
        if (accept) begin
          state_n = ST_EN;
          load    = 1'b1;
        end
      end
      ST_EN: begin
        if (accept) state_n = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (hit) begin
          state_n = ST_CAP2;
          load    = 1'b1;
        end else if (tmo) begin
          state_n = ST_ERR;
          busy_n  = 1'b0;
          err_n   = 1'b1;
        end
      end
      ST_CAP2: begin
        if (accept) begin
          state_n = ST_SPD;
          load    = 1'b1;
        end
      end
      ST_SPD: begin
        if (accept) state_n = ST_WAIT2;
      end
      ST_WAIT2: begin
        if (hit) begin
          state_n = ST_IDLE;
          busy_n  = 1'b0;
          done_n  = 1'b1;
        end else if (tmo) begin
          state_n = ST_ERR;
          busy_n  = 1'b0;
          err_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Write content for the state being entered
  always_comb begin
    ld_addr = '0;
    ld_data = '0;
    unique case (state_n)
      ST_DIS:  begin ld_addr = CTRL_ADDR; ld_data = D_DIS;    end
      ST_OVR:  begin ld_addr = tab_addr;  ld_data = tab_data; end
      ST_CAP1: begin ld_addr = LCAP_ADDR; ld_data = D_CAP1;   end
      ST_EN:   begin ld_addr = CTRL_ADDR; ld_data = D_EN;     end
      ST_CAP2: begin ld_addr = LCAP_ADDR; ld_data = D_CAP2;   end
      ST_SPD:  begin ld_addr = G2_ADDR;   ld_data = D_SPD;    end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      busy_o  <= busy_n;
      done_o  <= done_n;
      error_o <= err_n;
    end
  end
endmodule

// File: rtl/lr_link_recovery_chk.sv
module lr_link_recovery_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          error_o
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_write_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> busy_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !error_o);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    error_o && !start_i |=> error_o);

  assert_err_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    error_o |-> !busy_o && !wr_valid_o);

  assert_busy_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o && $rose(busy_o) |=> busy_o);
endmodule

bind lr_link_recovery_seq lr_link_recovery_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
  .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/tb_lr_link_recovery_seq.sv
module tb_lr_link_recovery_seq;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 6;
  localparam int TW = 16;
  localparam int NOVR = 3;
  localparam logic [AW-1:0] CA = 16'h0030;
  localparam logic [AW-1:0] LA = 16'h007C;
  localparam logic [AW-1:0] GA = 16'h080C;
  localparam logic [DW-1:0] CB = 32'h0820_0400;
  localparam logic [DW-1:0] LB = 32'h0003_F412;
  localparam logic [DW-1:0] GB = 32'h0000_010F;
  localparam logic [8*AW-1:0] OA = {16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
                                    16'h1104, 16'h1010, 16'h1002};
  localparam logic [8*DW-1:0] OD = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                    32'h0000_00A5, 32'h0000_3C00, 32'h8000_0001};
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LW-1:0] ltssm = '0;
  logic [TW-1:0] tmo_in = TW'(TMO);
  logic wr_ready = 1'b0;
  logic wr_valid, busy, done, error;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #10 clk = ~clk;

  lr_link_recovery_seq #(
    .AW(AW), .DW(DW), .LW(LW), .TW(TW), .OVR_COUNT(NOVR),
    .CTRL_ADDR(CA), .LCAP_ADDR(LA), .G2_ADDR(GA),
    .CTRL_BASE(CB), .LCAP_BASE(LB), .G2_BASE(GB),
    .OVR_ADDRS(OA), .OVR_DATAS(OD)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start), .ltssm_state_i(ltssm),
    .timeout_i(tmo_in), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy),
    .done_o(done), .error_o(error)
  );

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int cyc = 0;
  int wr_count = 0;
  int done_count = 0;
  logic [AW-1:0] log_a [$];
  logic [DW-1:0] log_d [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model, updated on every rising edge
  int m_phase = 0;
  int m_k = 0;
  bit m_prev = 0;
  bit m_busy = 0, m_done = 0, m_err = 0, m_valid = 0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;
  logic [AW-1:0] qa [$];
  logic [DW-1:0] qd [$];

  function automatic void fill_pre();
    qa.delete(); qd.delete();
    qa.push_back(CA); qd.push_back(CB & ~(32'h1 << 10));
    for (int i = 0; i < NOVR; i++) begin
      qa.push_back(OA[i*AW +: AW]); qd.push_back(OD[i*DW +: DW]);
    end
    qa.push_back(LA); qd.push_back({LB[31:4], 4'b0001});
    qa.push_back(CA); qd.push_back(CB | (32'h1 << 10));
  endfunction

  function automatic void fill_post();
    qa.delete(); qd.delete();
    qa.push_back(LA); qd.push_back({LB[31:4], 4'b0010});
    qa.push_back(GA); qd.push_back(GB | (32'h1 << 17));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_busy = 0; m_done = 0; m_err = 0; m_valid = 0;
      qa.delete(); qd.delete();
    end else begin
      m_done = 0;
      case (m_phase)
        0, 5: if (start) begin
          m_busy = 1; m_err = 0; fill_pre();
          m_valid = 1; m_addr = qa[0]; m_data = qd[0]; m_phase = 1;
        end
        1, 3: if (m_valid && wr_ready) begin
          void'(qa.pop_front()); void'(qd.pop_front());
          if (qa.size() > 0) begin
            m_addr = qa[0]; m_data = qd[0];
          end else begin
            m_valid = 0; m_phase = m_phase + 1; m_k = 0; m_prev = 0;
          end
        end
        default: begin
          if (m_prev && (ltssm == 6'd17)) begin
            if (m_phase == 2) begin
              fill_post(); m_valid = 1; m_addr = qa[0]; m_data = qd[0];
              m_phase = 3;
            end else begin
              m_busy = 0; m_done = 1; m_phase = 0;
            end
          end else if (m_k >= TMO) begin
            m_busy = 0; m_err = 1; m_phase = 5;
          end else begin
            m_k++; m_prev = (ltssm == 6'd17);
          end
        end
      endcase
    end
  end

  // Compare, drive ready, log handshakes
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(wr_valid === m_valid, "R10", "wr_valid", wr_valid, m_valid);
      if (m_valid) begin
        check(wr_addr === m_addr, "R10", "wr_addr", wr_addr, m_addr);
        check(wr_data === m_data, "R10", "wr_data", wr_data, m_data);
      end
      check(busy === m_busy, "R8", "busy", busy, m_busy);
      check(done === m_done, "R9", "done", done, m_done);
      check(error === m_err, "R7", "error", error, m_err);
      if (done) done_count++;
    end
    wr_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    if (wr_valid && wr_ready) begin
      wr_count++;
      log_a.push_back(wr_addr); log_d.push_back(wr_data);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wr_count < n) @(negedge clk);
  endtask

  task automatic begin_run();
    wr_count = 0; done_count = 0; log_a.delete(); log_d.delete();
  endtask

  task automatic check_log(input string tag);
    check(log_a.size() == NOVR + 5, tag, "write count", log_a.size(), NOVR + 5);
    if (log_a.size() == NOVR + 5) begin
      check(log_a[0] == CA && log_d[0] == (CB & ~(32'h1 << 10)), "R2",
            "disable write", log_d[0], CB & ~(32'h1 << 10));
      for (int i = 0; i < NOVR; i++)
        check(log_a[1+i] == OA[i*AW +: AW] && log_d[1+i] == OD[i*DW +: DW], "R3",
              "override entry", log_d[1+i], OD[i*DW +: DW]);
      check(log_a[NOVR+1] == LA && log_d[NOVR+1][3:0] == 4'b0001, "R4",
            "gen1 cap", log_d[NOVR+1], {LB[31:4], 4'b0001});
      check(log_a[NOVR+2] == CA && log_d[NOVR+2] == (CB | (32'h1 << 10)), "R4",
            "enable write", log_d[NOVR+2], CB | (32'h1 << 10));
      check(log_a[NOVR+3] == LA && log_d[NOVR+3][3:0] == 4'b0010, "R6",
            "gen2 cap", log_d[NOVR+3], {LB[31:4], 4'b0010});
      check(log_a[NOVR+4] == GA && log_d[NOVR+4] == (GB | (32'h1 << 17)), "R6",
            "speed change", log_d[NOVR+4], GB | (32'h1 << 17));
    end
  endtask

  // Successful run with a one-cycle glitch of 17 in the first wait
  task automatic run_success(input bit poke_start);
    begin_run();
    pulse_start();
    if (poke_start) begin
      cycles(2);
      check(busy == 1'b1, "R8", "busy before ignored start", busy, 1);
      pulse_start();
    end
    wait_writes(NOVR + 3);
    cycles(3);
    ltssm = 6'd17; cycles(1);
    ltssm = 6'd5;  cycles(4);
    check(wr_count == NOVR + 3, "R5", "no write after lone L0 sample", wr_count, NOVR + 3);
    ltssm = 6'd17;
    wait_writes(NOVR + 4);
    ltssm = 6'd8;
    wait_writes(NOVR + 5);
    cycles(4);
    ltssm = 6'd17;
    while (done_count == 0 && !error) @(negedge clk);
    cycles(2);
    ltssm = 6'd0;
    check(done_count == 1, "R9", "done pulses", done_count, 1);
    check_log(poke_start ? "R8" : "R4");
  endtask

  initial begin
    rst = 1'b1;
    cycles(3);
    check({busy, done, error, wr_valid} == 4'b0, "R1", "outputs in reset",
          {busy, done, error, wr_valid}, 0);
    rst = 1'b0;
    cycles(2);
    check({busy, done, error, wr_valid} == 4'b0, "R1", "outputs after reset",
          {busy, done, error, wr_valid}, 0);

    ready_mode = 0;
    run_success(1'b0);

    ready_mode = 1;
    run_success(1'b1);

    // Timeout in the first wait
    begin_run();
    ltssm = 6'd0;
    pulse_start();
    while (!error) @(negedge clk);
    cycles(30);
    check(error == 1'b1 && busy == 1'b0, "R7", "error held", error, 1);
    check(wr_count == NOVR + 3, "R7", "writes before timeout", wr_count, NOVR + 3);

    // Restart from error, time out in the second wait
    begin_run();
    pulse_start();
    check(error == 1'b0, "R7", "error cleared by start", error, 0);
    wait_writes(NOVR + 3);
    ltssm = 6'd17;
    wait_writes(NOVR + 5);
    ltssm = 6'd3;
    while (!error) @(negedge clk);
    check(done_count == 0, "R7", "no done on timeout", done_count, 0);
    ltssm = 6'd0;

    // Recover fully from error
    ready_mode = 0;
    run_success(1'b0);

    cycles(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule